// File: doc/BRIEF.md
# Transmit Queue with Fill-Level Interrupt

This block is an eight-entry queue placed between the processor's transmit-buffer write port and a serial transmitter. Every byte or nine-bit character enters through that single write port, and nothing else can write to the queue. The transmitter removes the oldest entry whenever its shift register can accept a new character. The block itself handles no serialisation or baud timing.

A programmable threshold compares against the number of stored entries. The interrupt line is high whenever that number is at or below the threshold, so software can refill the queue before it runs dry. The current fill count can be read at all times. A flush command empties the queue. A write into a full queue is discarded and sets a sticky error flag.

When the enable input is low, the block behaves as a single transmit buffer. It holds at most one entry, and the interrupt then means "buffer empty".

Top module: `txq_level_fifo`

## Requirements
- R1: A synchronous reset makes `fill_count` 0, `tx_valid` 0, `irq_level` 1 and `ovf_err` 0, whatever the queue held before.
- R2: With `cfg_en` high, entries leave in the order they were written. While `tx_valid` is high, `tx_data` shows the oldest stored entry. A pop is a clock edge with `tx_ready` high and `tx_valid` high.
- R3: A write (`wr_valid` high) while the queue holds its capacity is dropped, even if a pop happens in the same cycle. The stored entries and their order are unchanged, and `ovf_err` is 1 after that edge.
- R4: `ovf_err` stays 1 until an edge with `err_clr` high and no new overflow. An overflow in the same cycle as `err_clr` leaves the flag set.
- R5: After each edge, `fill_count` equals the number of entries stored, from 0 to 8.
- R6: With `cfg_en` high, after each edge `irq_level` is 1 exactly when `fill_count` is less than or equal to the `cfg_level` value present at that edge.
- R7: An edge with `flush` high leaves `fill_count` 0 and `tx_valid` 0. A write or pop in that same cycle is ignored and raises no overflow.
- R8: A write and a pop in the same cycle on a queue that is neither empty nor full leave `fill_count` unchanged and keep the order of the entries.
- R9: With `cfg_en` low, the capacity is one entry. A second write before a pop overflows and keeps the first entry. `irq_level` is 1 exactly when the buffer is empty.
- R10: A pop request (`tx_ready` high) on an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | 1: eight-entry queue, 0: single buffer |
| cfg_level | input | 4 | Fill-level threshold for `irq_level` |
| wr_valid | input | 1 | Transmit-buffer write strobe |
| wr_data | input | 9 | Character written |
| flush | input | 1 | Empty the queue |
| err_clr | input | 1 | Clear the overflow flag |
| tx_ready | input | 1 | Transmitter can take the head entry |
| tx_valid | output | 1 | Queue holds at least one entry |
| tx_data | output | 9 | Oldest entry |
| fill_count | output | 4 | Number of stored entries |
| irq_level | output | 1 | Fill level at or below threshold |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
A vector sequence at a fixed threshold interleaves writes, pops, simultaneous write-and-pop, pops on an empty queue and a flush that collides with both a write and a pop. It tells ordering errors apart from count errors, and it catches a threshold compared with the wrong relation when the count crosses the level of two. Directed runs fill the queue to capacity, wrapping the pointers, and overflow it. They check that the drained data is intact, then move the threshold to both ends of its range. The sticky flag is checked both against a clear alone and against a clear that collides with an overflow. A final run with the queue disabled separates the one-entry capacity from the full depth.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Decoded operation for one clock cycle
  typedef struct packed {
    logic push;   // entry is stored
    logic pop;    // head entry is consumed
    logic flush;  // queue is emptied
    logic ovf;    // write discarded on a full queue
  } txq_op_t;
endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  // Plain array without reset so it maps onto distributed RAM
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Show-ahead read: head is visible without a request cycle
  assign rdata = store[raddr];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_valid,
  input  logic             pop_req,
  input  logic             flush,
  output txq_op_t          op,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);
  localparam logic [CNT_W-1:0] CAP_Q   = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_ONE = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cap;
  logic             full;
  logic             empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_TOP) ? '0 : p + PTR_W'(1);
  endfunction

  assign cap   = en ? CAP_Q : CAP_ONE;
  assign full  = (cnt_q >= cap);
  assign empty = (cnt_q == '0);

  always_comb begin
    op.flush = flush;
    op.push  = wr_valid & ~full  & ~flush;
    op.ovf   = wr_valid &  full  & ~flush;
    op.pop   = pop_req  & ~empty & ~flush;
  end

  always_comb begin
    if (op.flush)                cnt_next = '0;
    else if (op.push && !op.pop) cnt_next = cnt_q + CNT_W'(1);
    else if (op.pop && !op.push) cnt_next = cnt_q - CNT_W'(1);
    else                         cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || op.flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (op.push) wr_ptr <= bump(wr_ptr);
      if (op.pop)  rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_next;
    end
  end

  // R5: count never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP_Q);

  // R7: flush empties the queue in one cycle
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> cnt_q == '0);

  // R8: simultaneous push and pop hold the count
  p_push_pop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && pop_req && !flush && !full && !empty) |=> $stable(cnt_q));

  // R10: pop request on an empty queue leaves it empty
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !wr_valid) |=> cnt_q == '0);
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             ovf_evt,
  input  logic             err_clr,
  output logic             irq,
  output logic             valid,
  output logic             ovf_err
);
  logic irq_next;

  // Disabled: single buffer, request means "empty"
  assign irq_next = en ? (cnt_next <= level) : (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b1;
      valid   <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      irq   <= irq_next;
      valid <= (cnt_next != '0);
      if (ovf_evt)      ovf_err <= 1'b1;
      else if (err_clr) ovf_err <= 1'b0;
    end
  end

  // R6 / R9: registered request agrees with the stored count
  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ($past(en) ? (cnt_q <= $past(level)) : (cnt_q == '0)));

  // R4: overflow sets the flag, even against a clear
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_err);

  // R4: flag holds without a clear
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !err_clr) |=> ovf_err);

  // R4: clear without a new overflow drops the flag
  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !ovf_evt) |=> !ovf_err);
endmodule

// File: rtl/txq_level_fifo.sv
module txq_level_fifo
  import txq_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [CNT_W-1:0]  cfg_level,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  input  logic              err_clr,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [CNT_W-1:0]  fill_count,
  output logic              irq_level,
  output logic              ovf_err
);
  txq_op_t          op;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  txq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .wr_valid (wr_valid),
    .pop_req  (tx_ready),
    .flush    (flush),
    .op       (op),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  txq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk   (clk),
    .we    (op.push),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (tx_data)
  );

  txq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .level    (cfg_level),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next),
    .ovf_evt  (op.ovf),
    .err_clr  (err_clr),
    .irq      (irq_level),
    .valid    (tx_valid),
    .ovf_err  (ovf_err)
  );

  assign fill_count = cnt_q;

  // R3: write on a full, enabled queue keeps count and flags an error
  p_full_write_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && wr_valid && !flush && !tx_ready && fill_count == CNT_W'(DEPTH))
      |=> (ovf_err && fill_count == CNT_W'(DEPTH)));

  // R2: valid flag follows the count
  p_valid_count_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid == (fill_count != '0));

  // R9: disabled mode never grows beyond one entry from at most one
  p_single_buf_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && fill_count <= CNT_W'(1)) |=> fill_count <= CNT_W'(1));
endmodule

// File: tb/txq_level_fifo_test.sv
`timescale 1ns/100ps
module txq_level_fifo_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b1;
  logic [3:0] cfg_level = 4'd2;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       flush = 1'b0;
  logic       err_clr = 1'b0;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [8:0] tx_data;
  logic [3:0] fill_count;
  logic       irq_level;
  logic       ovf_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txq_level_fifo uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_level(cfg_level),
    .wr_valid(wr_valid), .wr_data(wr_data), .flush(flush), .err_clr(err_clr),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .fill_count(fill_count), .irq_level(irq_level), .ovf_err(ovf_err)
  );

  typedef struct packed {
    logic       wr;
    logic [8:0] d;
    logic       pop;
    logic       fl;
    logic [3:0] c;
    logic       v;
    logic       chkd;
    logic [8:0] q;
    logic       irq;
    logic       ovf;
  } vec_t;

  // threshold 2, queue enabled
  localparam vec_t VT [12] = '{
    '{1'b1, 9'h101, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1, 9'h101, 1'b1, 1'b0},
    '{1'b1, 9'h0A2, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 9'h101, 1'b1, 1'b0},
    '{1'b1, 9'h0B3, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1, 9'h101, 1'b0, 1'b0},
    '{1'b0, 9'h000, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 9'h0A2, 1'b1, 1'b0},
    '{1'b1, 9'h0C4, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 9'h0B3, 1'b1, 1'b0}, // R8
    '{1'b0, 9'h000, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 9'h0C4, 1'b1, 1'b0},
    '{1'b0, 9'h000, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0},
    '{1'b0, 9'h000, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0}, // R10
    '{1'b1, 9'h1FF, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1, 9'h1FF, 1'b1, 1'b0},
    '{1'b1, 9'h000, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 9'h1FF, 1'b1, 1'b0},
    '{1'b1, 9'h055, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0}, // R7
    '{1'b1, 9'h055, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1, 9'h055, 1'b1, 1'b0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, let one edge pass, return at the next negedge
  task automatic step(input logic wr, input logic [8:0] d, input logic pop,
                      input logic fl, input logic clr);
    wr_valid = wr; wr_data = d; tx_ready = pop; flush = fl; err_clr = clr;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; tx_ready = 1'b0; flush = 1'b0; err_clr = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 9'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "count", fill_count, 0);
    check("R1", "valid", tx_valid, 0);
    check("R1", "irq", irq_level, 1);
    check("R1", "ovf", ovf_err, 0);

    // vector table: R2 order, R5 count, R6 threshold, R7 flush, R8, R10
    foreach (VT[i]) begin
      step(VT[i].wr, VT[i].d, VT[i].pop, VT[i].fl, 1'b0);
      check("R5", $sformatf("vec%0d count", i), fill_count, VT[i].c);
      check("R2", $sformatf("vec%0d valid", i), tx_valid, VT[i].v);
      if (VT[i].chkd) check("R2", $sformatf("vec%0d data", i), tx_data, VT[i].q);
      check("R6", $sformatf("vec%0d irq", i), irq_level, VT[i].irq);
      check("R7", $sformatf("vec%0d ovf", i), ovf_err, VT[i].ovf);
    end

    // fill to capacity, pointers wrap (R2, R5)
    step(1'b0, 9'h0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) step(1'b1, 9'h010 + 9'(k), 1'b0, 1'b0, 1'b0);
    check("R5", "full count", fill_count, 8);
    check("R6", "full irq level2", irq_level, 0);
    // R3: overflow with a simultaneous pop still drops the write
    step(1'b1, 9'h1AA, 1'b1, 1'b0, 1'b0);
    check("R3", "ovf set", ovf_err, 1);
    check("R3", "count after ovf+pop", fill_count, 7);
    check("R3", "head after ovf", tx_data, 9'h011);
    step(1'b1, 9'h017, 1'b0, 1'b0, 1'b0);
    step(1'b1, 9'h1BB, 1'b0, 1'b0, 1'b0);
    check("R3", "count held", fill_count, 8);
    // R6: threshold at top
    cfg_level = 4'd8;
    idle();
    check("R6", "irq level8 count8", irq_level, 1);
    check("R4", "ovf sticky", ovf_err, 1);
    // drain and verify intact order
    for (int k = 1; k < 8; k++) begin
      check("R3", $sformatf("drain %0d", k), tx_data, 9'h010 + 9'(k));
      step(1'b0, 9'h0, 1'b1, 1'b0, 1'b0);
    end
    check("R3", "last entry", tx_data, 9'h017);
    step(1'b0, 9'h0, 1'b1, 1'b0, 1'b0);
    check("R5", "drained", fill_count, 0);
    // R4: clear
    step(1'b0, 9'h0, 1'b0, 1'b0, 1'b1);
    check("R4", "cleared", ovf_err, 0);
    // R4: overflow with clear in same cycle
    for (int k = 0; k < 8; k++) step(1'b1, 9'(k), 1'b0, 1'b0, 1'b0);
    step(1'b1, 9'h0EE, 1'b0, 1'b0, 1'b1);
    check("R4", "set beats clear", ovf_err, 1);
    // R7: flush on full, no overflow raised by the colliding write
    step(1'b1, 9'h0EE, 1'b0, 1'b1, 1'b1);
    check("R7", "flush count", fill_count, 0);
    check("R7", "flush no ovf", ovf_err, 0);
    // R6: threshold zero
    cfg_level = 4'd0;
    step(1'b1, 9'h031, 1'b0, 1'b0, 1'b0);
    check("R6", "level0 count1", irq_level, 0);
    step(1'b0, 9'h0, 1'b1, 1'b0, 1'b0);
    check("R6", "level0 count0", irq_level, 1);

    // R9: disabled, single buffer
    cfg_en = 1'b0;
    cfg_level = 4'd8;
    step(1'b1, 9'h033, 1'b0, 1'b0, 1'b0);
    check("R9", "count one", fill_count, 1);
    check("R9", "irq busy", irq_level, 0);
    step(1'b1, 9'h044, 1'b0, 1'b0, 1'b0);
    check("R9", "second write ovf", ovf_err, 1);
    check("R9", "count stays one", fill_count, 1);
    check("R9", "first kept", tx_data, 9'h033);
    step(1'b0, 9'h0, 1'b1, 1'b0, 1'b0);
    check("R9", "irq empty", irq_level, 1);
    check("R9", "valid low", tx_valid, 0);

    // R1: reset with content and error pending
    cfg_en = 1'b1;
    step(1'b1, 9'h077, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    idle();
    rst = 1'b0;
    check("R1", "count after rst", fill_count, 0);
    check("R1", "ovf after rst", ovf_err, 0);
    check("R1", "valid after rst", tx_valid, 0);
    check("R1", "irq after rst", irq_level, 1);

    finish_run();
  end
endmodule